// File: doc/BRIEF.md
# Gauge Controller Command Decoder

This block sits behind an SPI shift-register front end in a two-gauge stepper driver. The front end hands over each complete 16-bit word with a one-cycle word-valid strobe, issued when chip-select rises. The top three bits of the word select a target. The remaining thirteen bits carry that target's data.

A word addressed to the power/enable/calibration target updates the two gauge driver enables, and standby follows from them. The same word may ask for an oscillator calibration, which is granted only when it is safe. The write can be turned into a pure status poll, and it is thrown away if any reserved bit is set. Words aimed at velocity, position and return-to-zero targets are only captured into raw holding registers for the stepping logic. On every word the block latches an 8-bit status byte for the shifter to send out during the following frame.

Top module: `gauge_cmd_decoder`

## Requirements
- R1: Word bits [15:13] select the target. Codes 001, 010, 011, 100 and 101 load word bits [12:0] into the velocity, gauge-0 position, gauge-1 position, return-to-zero and return-to-zero-confirm holding registers respectively, one cycle after the strobe. All other holding registers keep their values.
- R2: An accepted control write (code 000) sets `drv_en[0]` from bit 0 and `drv_en[1]` from bit 1 of the word, one cycle after the strobe.
- R3: `standby` is 1 exactly when both driver enables are 0.
- R4: A control write with bit 12 set changes no state: enables, calibration outputs and the refused flag all keep their values.
- R5: A control write with any of bits [11:5] set is rejected as a whole and changes no state.
- R6: An accepted control write with bit 3 set, arriving while both enables are 0 or both `moving` bits are 0, gives a one-cycle `cal_req` in the cycle after the strobe. The same write loads `cal_slow` from bit 2 and `cal_centred` from bit 4.
- R7: If that request arrives while a gauge is enabled and a pointer is moving, no pulse is given and the sticky refused flag is set. Every later accepted control write replaces the flag, so one without a refused calibration clears it.
- R8: Codes 110 and 111 are ignored and change no state.
- R9: On each strobe, `stat_byte` takes a new value and holds it until the next strobe. Its fields are: [1:0] driver enables and [2] standby, both as they stood before the word; [3] the refused flag before the word; [5:4] `moving`; [7:6] `overtemp`.
- R10: After reset the enables are 00, `standby` is 1, `cal_req`, `cal_slow`, `cal_centred` and `stat_byte` are 0, and all holding registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | One-cycle strobe marking a complete received word |
| word_in | input | 16 | Received word: target code [15:13], data [12:0] |
| moving | input | 2 | Pointer-in-motion flag per gauge |
| overtemp | input | 2 | Over-temperature flag per gauge |
| drv_en | output | 2 | Gauge driver enables |
| standby | output | 1 | Low-power mode, both drivers off |
| cal_req | output | 1 | One-cycle calibration start pulse |
| cal_slow | output | 1 | Slowed-oscillator mode for the granted calibration |
| cal_centred | output | 1 | Centred (1) or capped (0) calibration target |
| vel_raw | output | 13 | Raw maximum-velocity data |
| pos0_raw | output | 13 | Raw gauge-0 position data |
| pos1_raw | output | 13 | Raw gauge-1 position data |
| rtz_raw | output | 13 | Raw return-to-zero data |
| rtzc_raw | output | 13 | Raw return-to-zero confirmation data |
| stat_byte | output | 8 | Status for the next frame |

## Verification
The bench sends a calibration request while a gauge is enabled and its pointer is moving. A design that checked the wrong condition would pulse `cal_req` there, and it would also refuse the legal case where both enables are 0 but the pointers still report motion. A null word, a word with a reserved bit set and the two unused codes are each followed by a check that the enables and the refused flag did not change; a decoder that masked only part of the word would alter one of them. The status byte is checked against the state before the word, so a design that latched the state after the update would show the new enables.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = WORD_W - ADDR_W;
  localparam int N_GAUGE = 2;
  localparam int N_TGT   = 1 << ADDR_W;
  localparam int N_HOLD  = 5;
  localparam int STAT_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    T_CTRL = 3'd0, T_VEL = 3'd1, T_POS0 = 3'd2, T_POS1 = 3'd3,
    T_RTZ  = 3'd4, T_RTZC = 3'd5, T_FREE = 3'd6, T_TEST = 3'd7
  } tgt_e;

  // control-word bit positions
  localparam int B_EN0  = 0;
  localparam int B_EN1  = 1;
  localparam int B_SLOW = 2;
  localparam int B_CAL  = 3;
  localparam int B_CTR  = 4;
  localparam int B_RSVL = 5;
  localparam int B_RSVH = 11;
  localparam int B_NULL = 12;
endpackage

// File: rtl/gcd_addr_decode.sv
module gcd_addr_decode
  import gcd_pkg::*;
(
  input  logic              vld,
  input  logic [ADDR_W-1:0] code,
  output logic [N_TGT-1:0]  sel
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < N_TGT; i++) begin
      if (vld && (code == ADDR_W'(i))) sel[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gcd_ctrl_reg.sv
module gcd_ctrl_reg
  import gcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [DATA_W-1:0]  data,
  input  logic [N_GAUGE-1:0] moving,
  output logic [N_GAUGE-1:0] drv_en,
  output logic               standby,
  output logic               cal_req,
  output logic               cal_slow,
  output logic               cal_centred,
  output logic               refused
);
  logic [N_GAUGE-1:0] en_q, en_d;
  logic cal_q, cal_d, slow_q, slow_d, ctr_q, ctr_d, ref_q, ref_d;
  logic accept, cal_ask, cal_ok;

  always_comb begin
    accept  = wr && !data[B_NULL] && (data[B_RSVH:B_RSVL] == '0);
    cal_ask = data[B_CAL];
    cal_ok  = (en_q == '0) || (moving == '0);
    en_d    = en_q;
    ref_d   = ref_q;
    slow_d  = slow_q;
    ctr_d   = ctr_q;
    cal_d   = 1'b0;
    if (accept) begin
      en_d  = data[N_GAUGE-1:0];
      ref_d = cal_ask && !cal_ok;
      if (cal_ask && cal_ok) begin
        cal_d  = 1'b1;
        slow_d = data[B_SLOW];
        ctr_d  = data[B_CTR];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cal_q  <= 1'b0;
      slow_q <= 1'b0;
      ctr_q  <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      cal_q  <= cal_d;
      slow_q <= slow_d;
      ctr_q  <= ctr_d;
      ref_q  <= ref_d;
    end
  end

  assign drv_en      = en_q;
  assign standby     = (en_q == '0);
  assign cal_req     = cal_q;
  assign cal_slow    = slow_q;
  assign cal_centred = ctr_q;
  assign refused     = ref_q;
endmodule

// File: rtl/gcd_hold_regs.sv
module gcd_hold_regs
  import gcd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_HOLD-1:0]            load,
  input  logic [DATA_W-1:0]            data,
  output logic [N_HOLD-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < N_HOLD; i++) begin : g_hold
    logic [DATA_W-1:0] r_q, r_d;
    always_comb r_d = load[i] ? data : r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end
    assign q[i] = r_q;
  end
endmodule

// File: rtl/gcd_status.sv
module gcd_status
  import gcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld,
  input  logic [N_GAUGE-1:0] drv_en,
  input  logic               standby,
  input  logic               refused,
  input  logic [N_GAUGE-1:0] moving,
  input  logic [N_GAUGE-1:0] overtemp,
  output logic [STAT_W-1:0]  stat
);
  logic [STAT_W-1:0] s_q, s_d;
  always_comb s_d = vld ? {overtemp, moving, refused, standby, drv_en} : s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= s_d;
  end
  assign stat = s_q;
endmodule

// File: rtl/gauge_cmd_decoder.sv
module gauge_cmd_decoder
  import gcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_vld,
  input  logic [WORD_W-1:0]    word_in,
  input  logic [N_GAUGE-1:0]   moving,
  input  logic [N_GAUGE-1:0]   overtemp,
  output logic [N_GAUGE-1:0]   drv_en,
  output logic                 standby,
  output logic                 cal_req,
  output logic                 cal_slow,
  output logic                 cal_centred,
  output logic [DATA_W-1:0]    vel_raw,
  output logic [DATA_W-1:0]    pos0_raw,
  output logic [DATA_W-1:0]    pos1_raw,
  output logic [DATA_W-1:0]    rtz_raw,
  output logic [DATA_W-1:0]    rtzc_raw,
  output logic [STAT_W-1:0]    stat_byte
);
  logic [N_TGT-1:0]              sel;
  logic [DATA_W-1:0]             data;
  logic                          refused;
  logic [N_HOLD-1:0][DATA_W-1:0] hold;

  assign data = word_in[DATA_W-1:0];

  gcd_addr_decode u_dec (
    .vld (word_vld), .code(word_in[WORD_W-1:DATA_W]), .sel(sel)
  );

  gcd_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(sel[T_CTRL]), .data(data), .moving(moving),
    .drv_en(drv_en), .standby(standby), .cal_req(cal_req),
    .cal_slow(cal_slow), .cal_centred(cal_centred), .refused(refused)
  );

  gcd_hold_regs u_hold (
    .clk(clk), .rst_n(rst_n), .load(sel[T_RTZC:T_VEL]), .data(data), .q(hold)
  );

  gcd_status u_stat (
    .clk(clk), .rst_n(rst_n), .vld(word_vld), .drv_en(drv_en),
    .standby(standby), .refused(refused), .moving(moving),
    .overtemp(overtemp), .stat(stat_byte)
  );

  assign vel_raw  = hold[0];
  assign pos0_raw = hold[1];
  assign pos1_raw = hold[2];
  assign rtz_raw  = hold[3];
  assign rtzc_raw = hold[4];
endmodule

// File: rtl/gcd_checker.sv
module gcd_checker
  import gcd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               word_vld,
  input logic [WORD_W-1:0]  word_in,
  input logic [N_GAUGE-1:0] moving,
  input logic [N_GAUGE-1:0] drv_en,
  input logic               cal_req,
  input logic               refused,
  input logic [DATA_W-1:0]  vel_raw,
  input logic [DATA_W-1:0]  pos0_raw,
  input logic [STAT_W-1:0]  stat_byte
);
  logic is_ctrl, is_free;
  assign is_ctrl = word_vld && (word_in[WORD_W-1:DATA_W] == T_CTRL);
  assign is_free = word_vld && (word_in[WORD_W-1] && word_in[WORD_W-2]);

  // R6: a calibration pulse only follows a strobe taken while it was safe
  p_cal_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> ($past(word_vld) && ($past(drv_en) == '0 || $past(moving) == '0)));

  // R4: null command keeps enables and refused flag
  p_null_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && word_in[B_NULL]) |=> ($stable(drv_en) && $stable(refused) && !cal_req));

  // R5: reserved bits set reject the write
  p_resv_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && word_in[B_RSVH:B_RSVL] != '0) |=> ($stable(drv_en) && !cal_req));

  // R8: unused codes touch nothing
  p_free_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_free |=> ($stable(drv_en) && $stable(refused) && $stable(vel_raw)
                 && $stable(pos0_raw) && !cal_req));

  // R9: status byte moves only on a strobe
  p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(stat_byte));
endmodule

bind gauge_cmd_decoder gcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
  .moving(moving), .drv_en(drv_en), .cal_req(cal_req), .refused(refused),
  .vel_raw(vel_raw), .pos0_raw(pos0_raw), .stat_byte(stat_byte)
);

// File: tb/sim_gauge_cmd_decoder.sv
module sim_gauge_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_vld;
  logic [15:0] word_in;
  logic [1:0]  moving, overtemp;
  logic [1:0]  drv_en;
  logic        standby, cal_req, cal_slow, cal_centred;
  logic [12:0] vel_raw, pos0_raw, pos1_raw, rtz_raw, rtzc_raw;
  logic [7:0]  stat_byte;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gauge_cmd_decoder u0 (.*);

  // {word, moving, exp_en, exp_cal, exp_refused}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {16'h0003, 2'b00, 2'b11, 1'b0, 1'b0},  // R2 enable both
    {16'h000B, 2'b01, 2'b11, 1'b0, 1'b1},  // R7 refused while moving
    {16'h1000, 2'b00, 2'b11, 1'b0, 1'b1},  // R4 null
    {16'h0020, 2'b00, 2'b11, 1'b0, 1'b1},  // R5 reserved bit 5
    {16'h0001, 2'b01, 2'b01, 1'b0, 1'b0},  // R7 cleared, R2
    {16'h001D, 2'b00, 2'b01, 1'b1, 1'b0},  // R6 legal, not moving
    {16'h0000, 2'b10, 2'b00, 1'b0, 1'b0},  // R3 standby
    {16'h0008, 2'b11, 2'b00, 1'b1, 1'b0},  // R6 legal, gauges off
    {16'hC003, 2'b00, 2'b00, 1'b0, 1'b0},  // R8 code 110
    {16'hE003, 2'b00, 2'b00, 1'b0, 1'b0},  // R8 code 111
    {16'h0802, 2'b00, 2'b00, 1'b0, 1'b0},  // R5 reserved bit 11
    {16'h0002, 2'b00, 2'b10, 1'b0, 1'b0}   // R2 gauge 1 only
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic [1:0] mv);
    @(negedge clk);
    word_in  = w;
    moving   = mv;
    word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; word_vld = 1'b0; word_in = '0; moving = '0; overtemp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 en", 16'(drv_en), 16'h0);
    chk("R10 standby", 16'(standby), 16'h1);
    chk("R10 cal", 16'({cal_req, cal_slow, cal_centred}), 16'h0);
    chk("R10 stat", 16'(stat_byte), 16'h0);
    chk("R10 hold", 16'(vel_raw | pos0_raw | pos1_raw | rtz_raw | rtzc_raw), 16'h0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][21:6], VEC[i][5:4]);
      chk("R2 en", 16'(drv_en), 16'(VEC[i][3:2]));
      chk("R3 standby", 16'(standby), 16'(VEC[i][3:2] == 2'b00));
      chk("R6 cal_req", 16'(cal_req), 16'(VEC[i][1]));
      @(negedge clk);
      chk("R6 pulse width", 16'(cal_req), 16'h0);
      // refused flag is brought out through the next status byte (R7)
      send(16'h1000, 2'b00);
      chk("R7 refused", 16'(stat_byte[3]), 16'(VEC[i][0]));
    end
    // last granted calibration had bits 2 and 4 clear
    chk("R6 slow", 16'(cal_slow), 16'h0);
    chk("R6 centred", 16'(cal_centred), 16'h0);

    // R6 mode bits: slow set, centred clear (en now 10, not moving)
    send(16'h000E, 2'b00);
    chk("R6 req", 16'(cal_req), 16'h1);
    chk("R6 slow set", 16'(cal_slow), 16'h1);
    chk("R6 centred clr", 16'(cal_centred), 16'h0);

    // R9 status byte: pre-state en 10, refused 0; moving 10, overtemp 01
    overtemp = 2'b01;
    send(16'h1000, 2'b10);
    chk("R9 stat", 16'(stat_byte), 16'h62);
    @(negedge clk);
    overtemp = 2'b10;
    @(negedge clk);
    chk("R9 stat held", 16'(stat_byte), 16'h62);

    // R1 holding registers
    send(16'h2ABC, 2'b00);
    chk("R1 vel", 16'(vel_raw), 16'h0ABC);
    chk("R1 others", 16'(pos0_raw | pos1_raw | rtz_raw | rtzc_raw), 16'h0);
    send(16'h4123, 2'b00);
    chk("R1 pos0", 16'(pos0_raw), 16'h0123);
    send(16'h7FFF, 2'b00);
    chk("R1 pos1", 16'(pos1_raw), 16'h1FFF);
    send(16'h8005, 2'b00);
    chk("R1 rtz", 16'(rtz_raw), 16'h0005);
    send(16'hA00A, 2'b00);
    chk("R1 rtzc", 16'(rtzc_raw), 16'h000A);
    chk("R1 vel kept", 16'(vel_raw), 16'h0ABC);
    // R8: unused code must not disturb holding registers
    send(16'hDFFF, 2'b00);
    chk("R8 vel kept", 16'(vel_raw), 16'h0ABC);
    chk("R8 en kept", 16'(drv_en), 16'h2);

    // R10 reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 en after reset", 16'(drv_en), 16'h0);
    chk("R10 vel after reset", 16'(vel_raw), 16'h0);
    rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule